// File: doc/BRIEF.md
# CCD Pixel Timing Sequencer

This block sits on the host side of a serial CCD digitizer and runs one sensor line at a time. Each pixel takes one slot. In a slot the block may raise the black-level clamp strobe, then raises the video sample strobe. When that strobe falls, the digitizer takes its sample. The block then waits a quiet interval and clocks the 8-bit result back in over a serial clock. The read direction select is held high for the whole time. All pulse widths and gaps are parameters counted in system clock cycles. An elaboration-time check rejects any setting that would violate the digitizer's minimum widths, separations or serial clock rate. The default settings assume a 5 ns system clock.

The digitizer returns each result two sample strobes late. For this reason every line gets two extra flush slots after its last real pixel. The bytes read in the first two slots of a line belong to the previous line and are dropped. Every byte that is kept is presented with the index of the pixel it came from, and the last pixel of the line is flagged.

There are two clamp policies. In correlated double sampling mode the clamp pulses in every slot, flush slots included. In black-level mode it pulses only in the first `black_count_i` pixels of the line. The controller is one state machine with these states:
- `S_IDLE`: waiting for a line.
- `S_ARM`: one cycle that picks the slot's clamp policy.
- `S_CLAMP`: clamp strobe high.
- `S_CSEP`: gap between the clamp and the sample strobe.
- `S_VSAMP`: sample strobe high.
- `S_QUIET`: no edges after the sample strobe falls.
- `S_SHI`: serial clock high.
- `S_SLO`: serial clock low.
- `S_TAIL`: gap at the end of the slot.

Its transitions are:
- start: `S_IDLE`→`S_ARM` on an accepted trigger.
- `S_ARM`→`S_CLAMP` when the slot is clamped, else `S_ARM`→`S_VSAMP`.
- `S_CLAMP`→`S_CSEP`→`S_VSAMP`→`S_QUIET`→`S_SHI`→`S_SLO`, each when its timer expires.
- `S_SLO`→`S_SHI` for the next bit, or `S_SLO`→`S_TAIL` after the last bit.
- `S_TAIL`→`S_ARM` for the next slot, or `S_TAIL`→`S_IDLE` after the final flush slot.

Top module: `ccd_pixel_sequencer`

## Requirements
- R1: While reset is held and right after it, clamp_o, vidsamp_o, sclk_o, busy_o and byte_valid_o are low and mode_o is high.
- R2: Each clamp_o pulse lasts exactly CLAMP_CYC cycles (default 60) and each vidsamp_o pulse exactly VS_CYC cycles (default 100). Settings below 300 ns or 500 ns at CLK_NS per cycle are rejected at elaboration.
- R3: clamp_o and vidsamp_o are never high together. At least SEP_CYC cycles (default 10) pass from a clamp_o fall to the next vidsamp_o rise, and from a vidsamp_o fall to the next clamp_o rise.
- R4: After each vidsamp_o fall, sclk_o stays low for QUIET_CYC cycles (default 10). At that point the MSB is sampled from sdata_i. Seven sclk_o pulses follow, each SCLK_HI_CYC cycles high and SCLK_LO_CYC cycles low. One further bit is sampled at the end of each low phase, MSB first. This gives 7 rising edges per slot, and sclk_o is never high while vidsamp_o is high.
- R5: With cds_mode_i=1 the clamp pulses once in every slot of the line (N+2 pulses). With cds_mode_i=0 it pulses only in slots with index below black_count_i, never in flush slots (min(black_count_i, N) pulses).
- R6: A line_start_i pulse in idle with pixel_count_i = N ≥ 1 produces exactly N+2 vidsamp_o pulses and then returns to idle. With N = 0 the trigger is ignored and no strobe is produced.
- R7: The byte read in slot k (k counted from 0) belongs to pixel k-2. Slots 0 and 1 produce no output. Each kept byte appears as a one-cycle byte_valid_o pulse with byte_data_o, byte_index_o = k-2, and byte_eol_o high only for index N-1. A line yields exactly N bytes.
- R8: line_start_i, pixel_count_i, black_count_i and cds_mode_i are taken only when a line starts. Changes to them while busy_o is high have no effect on strobes or bytes.
- R9: mode_o is held high at all times (the digitizer drives read data).
- R10: busy_o rises the cycle after an accepted trigger and falls when the last flush slot ends. While busy_o is low, no strobe or serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | Line trigger, taken only in idle |
| pixel_count_i | input | PIXW | Number of real pixels in the line |
| black_count_i | input | PIXW | Number of leading shielded pixels clamped in black-level mode |
| cds_mode_i | input | 1 | 1: clamp every slot, 0: clamp shielded pixels only |
| sdata_i | input | 1 | Serial result bit from the digitizer |
| clamp_o | output | 1 | Black-level clamp strobe |
| vidsamp_o | output | 1 | Video sample strobe, sample taken on its fall |
| sclk_o | output | 1 | Serial read clock |
| mode_o | output | 1 | Direction select, constant high for read |
| busy_o | output | 1 | A line is in progress |
| byte_valid_o | output | 1 | One-cycle strobe for a kept byte |
| byte_data_o | output | 8 | Captured result |
| byte_index_o | output | PIXW | Pixel index the byte belongs to |
| byte_eol_o | output | 1 | Byte is the last pixel of the line |

## Verification
The hardest case to reach from the ports is a pipeline seam. Here a line's first two reads carry leftover samples from the previous line's flush slots. A slot-to-index error by one would then emit wrong data rather than no data. The bench models the digitizer with its two-deep result pipeline kept alive across lines. Each line uses its own sample seed, and lines run back to back with different lengths, clamp policies and a single-pixel line. Every stale byte is therefore distinct from any expected one. One long line also gets a second trigger and altered counts in mid-flight, to show that only the values taken at the start count.

// File: rtl/ccd_seq_pkg.sv
`timescale 1ns/1ps
package ccd_seq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM,
        S_CLAMP,
        S_CSEP,
        S_VSAMP,
        S_QUIET,
        S_SHI,
        S_SLO,
        S_TAIL
    } seq_state_t;
endpackage

// File: rtl/ccd_phase_timer.sv
`timescale 1ns/1ps
module ccd_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/ccd_line_tracker.sv
`timescale 1ns/1ps
module ccd_line_tracker #(
    parameter int PIXW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            advance,
    input  logic [PIXW-1:0] npix_i,
    input  logic [PIXW-1:0] nblack_i,
    input  logic            cds_i,
    output logic            clamp_now,
    output logic            last_slot,
    output logic            out_valid,
    output logic [PIXW-1:0] out_index,
    output logic            out_eol
);
    localparam int SW = PIXW + 1;

    logic [SW-1:0]   slot;
    logic [PIXW-1:0] npix, nblack;
    logic            cds;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot   <= '0;
            npix   <= '0;
            nblack <= '0;
            cds    <= 1'b0;
        end else if (start) begin
            slot   <= '0;
            npix   <= npix_i;
            nblack <= nblack_i;
            cds    <= cds_i;
        end else if (advance) begin
            slot   <= slot + SW'(1);
        end
    end

    assign clamp_now = cds || ((slot < {1'b0, nblack}) && (slot < {1'b0, npix}));
    assign last_slot = (slot == ({1'b0, npix} + SW'(1)));
    assign out_valid = (slot >= SW'(2));
    assign out_index = PIXW'(slot - SW'(2));
    assign out_eol   = last_slot;
endmodule

// File: rtl/ccd_serial_rx.sv
`timescale 1ns/1ps
module ccd_serial_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         last_bit
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            bcnt <= '0;
        end else if (clear) begin
            bcnt <= '0;
        end else if (sample) begin
            word <= {word[W-2:0], din};
            bcnt <= last_bit ? '0 : bcnt + CW'(1);
        end
    end

    assign last_bit = (bcnt == CW'(W - 1));
endmodule

// File: rtl/ccd_pixel_sequencer.sv
`timescale 1ns/1ps
module ccd_pixel_sequencer
    import ccd_seq_pkg::*;
#(
    parameter int PIXW        = 12,
    parameter int CLK_NS      = 5,
    parameter int CLAMP_CYC   = 60,
    parameter int VS_CYC      = 100,
    parameter int SEP_CYC     = 10,
    parameter int QUIET_CYC   = 10,
    parameter int SCLK_HI_CYC = 10,
    parameter int SCLK_LO_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic [PIXW-1:0]   pixel_count_i,
    input  logic [PIXW-1:0]   black_count_i,
    input  logic              cds_mode_i,
    input  logic              sdata_i,
    output logic              clamp_o,
    output logic              vidsamp_o,
    output logic              sclk_o,
    output logic              mode_o,
    output logic              busy_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o,
    output logic [PIXW-1:0]   byte_index_o,
    output logic              byte_eol_o
);
    localparam int M_A  = (CLAMP_CYC > VS_CYC) ? CLAMP_CYC : VS_CYC;
    localparam int M_B  = (SEP_CYC > QUIET_CYC) ? SEP_CYC : QUIET_CYC;
    localparam int M_C  = (SCLK_HI_CYC > SCLK_LO_CYC) ? SCLK_HI_CYC : SCLK_LO_CYC;
    localparam int M_AB = (M_A > M_B) ? M_A : M_B;
    localparam int MAXC = (M_AB > M_C) ? M_AB : M_C;
    localparam int TW   = $clog2(MAXC + 1);

    // Reject timing settings below the digitizer minimums.
    if (CLAMP_CYC * CLK_NS < 300 || VS_CYC * CLK_NS < 500 ||
        SEP_CYC * CLK_NS < 50 || QUIET_CYC * CLK_NS < 50 ||
        SCLK_HI_CYC * CLK_NS < 50 || SCLK_LO_CYC * CLK_NS < 50 ||
        (SCLK_HI_CYC + SCLK_LO_CYC) * CLK_NS < 100) begin : g_bad_timing
        $error("ccd_pixel_sequencer: timing parameter below minimum");
    end

    seq_state_t        state, state_n;
    logic              tdone, tload;
    logic [TW-1:0]     tval;
    logic              clamp_now, last_slot, out_valid, out_eol;
    logic [PIXW-1:0]   out_index;
    logic              last_bit, start, advance, sample, emit;
    logic [BYTE_W-1:0] word;

    function automatic logic [TW-1:0] dur_m1(seq_state_t s);
        case (s)
            S_CLAMP: return TW'(CLAMP_CYC - 1);
            S_CSEP:  return TW'(SEP_CYC - 1);
            S_VSAMP: return TW'(VS_CYC - 1);
            S_QUIET: return TW'(QUIET_CYC - 1);
            S_SHI:   return TW'(SCLK_HI_CYC - 1);
            S_SLO:   return TW'(SCLK_LO_CYC - 1);
            S_TAIL:  return TW'(SEP_CYC - 1);
            default: return '0;
        endcase
    endfunction

    ccd_phase_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .done(tdone)
    );

    ccd_line_tracker #(.PIXW(PIXW)) u_track (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .npix_i(pixel_count_i), .nblack_i(black_count_i), .cds_i(cds_mode_i),
        .clamp_now(clamp_now), .last_slot(last_slot), .out_valid(out_valid),
        .out_index(out_index), .out_eol(out_eol)
    );

    ccd_serial_rx #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(start), .sample(sample),
        .din(sdata_i), .word(word), .last_bit(last_bit)
    );

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (line_start_i && pixel_count_i != '0) state_n = S_ARM;
            S_ARM:   if (tdone) state_n = clamp_now ? S_CLAMP : S_VSAMP;
            S_CLAMP: if (tdone) state_n = S_CSEP;
            S_CSEP:  if (tdone) state_n = S_VSAMP;
            S_VSAMP: if (tdone) state_n = S_QUIET;
            S_QUIET: if (tdone) state_n = S_SHI;
            S_SHI:   if (tdone) state_n = S_SLO;
            S_SLO:   if (tdone) state_n = last_bit ? S_TAIL : S_SHI;
            S_TAIL:  if (tdone) state_n = last_slot ? S_IDLE : S_ARM;
            default: state_n = S_IDLE;
        endcase
    end

    assign tload   = (state_n != state);
    assign tval    = dur_m1(state_n);
    assign start   = (state == S_IDLE) && (state_n == S_ARM);
    assign advance = (state == S_TAIL) && tdone && !last_slot;
    assign sample  = tdone && ((state == S_QUIET) || (state == S_SLO));
    assign emit    = (state == S_SLO) && tdone && last_bit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clamp_o      <= 1'b0;
            vidsamp_o    <= 1'b0;
            sclk_o       <= 1'b0;
            busy_o       <= 1'b0;
            byte_valid_o <= 1'b0;
            byte_index_o <= '0;
            byte_eol_o   <= 1'b0;
        end else begin
            clamp_o      <= (state_n == S_CLAMP);
            vidsamp_o    <= (state_n == S_VSAMP);
            sclk_o       <= (state_n == S_SHI);
            busy_o       <= (state_n != S_IDLE);
            byte_valid_o <= emit && out_valid;
            byte_eol_o   <= emit && out_valid && out_eol;
            if (emit) byte_index_o <= out_index;
        end
    end

    assign mode_o      = 1'b1;
    assign byte_data_o = word;
endmodule

// File: rtl/ccd_seq_checker.sv
`timescale 1ns/1ps
module ccd_seq_checker #(
    parameter int CLAMP_CYC = 60,
    parameter int VS_CYC    = 100,
    parameter int SEP_CYC   = 10,
    parameter int QUIET_CYC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic clamp_o,
    input logic vidsamp_o,
    input logic sclk_o,
    input logic busy_o,
    input logic byte_valid_o
);
    logic [15:0] c_len, v_len, c_gap, v_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_len <= '0;
            v_len <= '0;
            c_gap <= 16'hFFFF;
            v_gap <= 16'hFFFF;
        end else begin
            c_len <= clamp_o   ? c_len + 16'd1 : 16'd0;
            v_len <= vidsamp_o ? v_len + 16'd1 : 16'd0;
            c_gap <= clamp_o   ? 16'd0 : ((c_gap == 16'hFFFF) ? c_gap : c_gap + 16'd1);
            v_gap <= vidsamp_o ? 16'd0 : ((v_gap == 16'hFFFF) ? v_gap : v_gap + 16'd1);
        end
    end

    a_r2_clamp_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_o) |-> (c_len == 16'(CLAMP_CYC)));
    a_r2_vs_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vidsamp_o) |-> (v_len == 16'(VS_CYC)));
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(clamp_o && vidsamp_o));
    a_r3_clamp_to_vs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vidsamp_o) |-> (c_gap >= 16'(SEP_CYC)));
    a_r3_vs_to_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_o) |-> (v_gap >= 16'(SEP_CYC)));
    a_r4_quiet_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (v_gap >= 16'(QUIET_CYC)));
    a_r4_no_sclk_in_vs: assert property (@(posedge clk) disable iff (!rst_n)
        vidsamp_o |-> !sclk_o);
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(clamp_o || vidsamp_o || sclk_o));
endmodule

bind ccd_pixel_sequencer ccd_seq_checker #(
    .CLAMP_CYC(CLAMP_CYC), .VS_CYC(VS_CYC), .SEP_CYC(SEP_CYC), .QUIET_CYC(QUIET_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clamp_o(clamp_o), .vidsamp_o(vidsamp_o),
    .sclk_o(sclk_o), .busy_o(busy_o), .byte_valid_o(byte_valid_o)
);

// File: tb/sim_ccd_pixel_sequencer.sv
`timescale 1ns/1ps
module sim_ccd_pixel_sequencer;
    localparam int PIXW = 12;
    localparam int CLAMP_C = 60, VS_C = 100, SEP_C = 10, QUIET_C = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic line_start_i = 1'b0, cds_mode_i = 1'b0, sdata_i;
    logic [PIXW-1:0] pixel_count_i = '0, black_count_i = '0;
    logic clamp_o, vidsamp_o, sclk_o, mode_o, busy_o, byte_valid_o, byte_eol_o;
    logic [7:0] byte_data_o;
    logic [PIXW-1:0] byte_index_o;

    int checks = 0, fails = 0;
    int cl_rises = 0, vs_rises = 0, sc_rises = 0;

    typedef struct packed {
        logic [7:0]      d;
        logic [PIXW-1:0] idx;
        logic            eol;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ccd_pixel_sequencer #(
        .PIXW(PIXW), .CLK_NS(5), .CLAMP_CYC(CLAMP_C), .VS_CYC(VS_C),
        .SEP_CYC(SEP_C), .QUIET_CYC(QUIET_C), .SCLK_HI_CYC(10), .SCLK_LO_CYC(10)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
        .pixel_count_i(pixel_count_i), .black_count_i(black_count_i),
        .cds_mode_i(cds_mode_i), .sdata_i(sdata_i), .clamp_o(clamp_o),
        .vidsamp_o(vidsamp_o), .sclk_o(sclk_o), .mode_o(mode_o), .busy_o(busy_o),
        .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
        .byte_index_o(byte_index_o), .byte_eol_o(byte_eol_o)
    );

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic logic [7:0] pv(input int ln, input int k);
        return 8'((ln * 53 + k * 29 + 17) & 255);
    endfunction

    // Digitizer model: two-deep result pipeline, serial out MSB first
    int m_line = 0, m_k = 0;
    logic [7:0] conv = '0, adc = '0, sh = '0;
    always @(negedge vidsamp_o or posedge sclk_o) begin
        if (sclk_o) sh <= {sh[6:0], 1'b0};
        else begin
            sh   <= adc;
            adc  <= conv;
            conv <= pv(m_line, m_k);
            m_k  <= m_k + 1;
        end
    end
    assign sdata_i = sh[7];

    always @(posedge clamp_o)   cl_rises++;
    always @(posedge vidsamp_o) vs_rises++;
    always @(posedge sclk_o)    sc_rises++;

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && byte_valid_o) begin
            if (q.size() == 0) chk("R7 unexpected byte", 1, 0);
            else begin
                exp_t e;
                e = q.pop_front();
                chk("R7 byte data", int'(byte_data_o), int'(e.d));
                chk("R7 byte index", int'(byte_index_o), int'(e.idx));
                chk("R7 end of line flag", int'(byte_eol_o), int'(e.eol));
            end
        end
    end

    // Width and separation monitor
    int crun = 0, vrun = 0, cgap = 1000, vgap = 1000;
    logic pc = 1'b0, pvs = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (clamp_o && !pc) chk("R3 vidsamp fall to clamp rise gap ok", int'(vgap >= SEP_C), 1);
            if (vidsamp_o && !pvs) chk("R3 clamp fall to vidsamp rise gap ok", int'(cgap >= SEP_C), 1);
            if (clamp_o && vidsamp_o) chk("R3 overlap", 1, 0);
            if (!clamp_o && pc) chk("R2 clamp width", crun, CLAMP_C);
            if (!vidsamp_o && pvs) chk("R2 vidsamp width", vrun, VS_C);
            crun = clamp_o ? crun + 1 : 0;
            vrun = vidsamp_o ? vrun + 1 : 0;
            cgap = clamp_o ? 0 : cgap + 1;
            vgap = vidsamp_o ? 0 : vgap + 1;
            pc = clamp_o;
            pvs = vidsamp_o;
        end
    end

    task automatic run_line(input logic cds, input int n, input int nb, input int ln, input bit inject);
        int exp_cl;
        for (int p = 0; p < n; p++)
            q.push_back('{d: pv(ln, p), idx: PIXW'(p), eol: 1'(p == n - 1)});
        exp_cl = cds ? n + 2 : ((nb < n) ? nb : n);
        cl_rises = 0; vs_rises = 0; sc_rises = 0;
        m_line = ln; m_k = 0;
        @(negedge clk);
        cds_mode_i = cds; pixel_count_i = PIXW'(n); black_count_i = PIXW'(nb);
        line_start_i = 1'b1;
        @(negedge clk);
        line_start_i = 1'b0;
        if (n == 0) begin
            repeat (20) @(negedge clk);
            chk("R6 zero-length trigger stays idle", int'(busy_o), 0);
            chk("R6 zero-length trigger no vidsamp", vs_rises, 0);
            chk("R5 zero-length trigger no clamp", cl_rises, 0);
            return;
        end
        chk("R10 busy after accepted trigger", int'(busy_o), 1);
        if (inject) begin
            repeat (400) @(negedge clk);
            chk("R9 mode high mid-line", int'(mode_o), 1);
            line_start_i = 1'b1; pixel_count_i = PIXW'(2); black_count_i = PIXW'(1);
            cds_mode_i = ~cds;
            @(negedge clk);
            line_start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R6 vidsamp pulses per line", vs_rises, n + 2);
        chk("R5 clamp pulses per line", cl_rises, exp_cl);
        chk("R4 sclk rises per line", sc_rises, 7 * (n + 2));
        chk("R7 all bytes delivered", q.size(), 0);
        chk("R10 idle after last flush slot", int'(busy_o), 0);
        if (inject) chk("R8 mid-line changes ignored (vidsamp count)", vs_rises, n + 2);
    endtask

    task automatic summary;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog expired actual=150000 expected=fewer cycles");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset clamp low", int'(clamp_o), 0);
        chk("R1 reset vidsamp low", int'(vidsamp_o), 0);
        chk("R1 reset sclk low", int'(sclk_o), 0);
        chk("R1 reset busy low", int'(busy_o), 0);
        chk("R1 reset valid low", int'(byte_valid_o), 0);
        chk("R9 mode high in reset", int'(mode_o), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", int'(busy_o), 0);
        run_line(1'b1, 4, 0, 1, 1'b0);
        run_line(1'b0, 5, 2, 2, 1'b0);
        run_line(1'b0, 3, 7, 3, 1'b0);
        run_line(1'b0, 1, 0, 4, 1'b0);
        run_line(1'b0, 0, 3, 5, 1'b0);
        run_line(1'b1, 6, 0, 6, 1'b1);
        run_line(1'b0, 2, 1, 7, 1'b0);
        summary();
        $finish;
    end
endmodule